// File: doc/BRIEF.md
# Cascadable Timer with Calendar Clock

This block is a small byte-addressed peripheral holding two 8-bit counters and a full calendar. In counter mode the two counters either count side by side on every accepted tick, or the second one counts only when the first wraps, which turns the pair into one 16-bit counter. In calendar mode the counters stand still. A 1 Hz enable then drives seconds, minutes, hours, day of week, day of month, month and a 16-bit year. The calendar shortens 30-day months and February, and gives February a 29th day in leap years.

Software reaches everything through one byte port: an address, a write strobe with write data, and combinational read data. An event raises a single-cycle `tick_out` pulse and sets a sticky flag. The event is a 16-bit or second-counter wrap in counter mode, or a minute boundary in calendar mode. The flag drives `irq` only while the interrupt-enable bit is set.

Top module: `cal_timer`

## Requirements
- R1: After reset, control, flag, both counters, seconds, minutes, hours, day of week and year read 0; day of month and month read 1; `irq` and `tick_out` are low.
- R2: In counter mode with chaining off (control bit 1 = 0), each accepted tick adds one to both counters, and each counter wraps from 255 to 0.
- R3: With chaining on (control bit 1 = 1), the first counter (address 2) advances on each accepted tick, and the second counter (address 3) advances only on a tick where the first counter goes from 255 to 0.
- R4: An event is a tick in counter mode on which the second counter goes from 255 to 0, or a tick in calendar mode on which seconds wrap to 0. `tick_out` is high for exactly the one cycle after the edge that accepts that tick.
- R5: An event sets the flag (address 1, bit 0). Writing bit 0 of address 1 loads the flag, but an event in the same cycle wins. `irq` is high only when the flag is set and control bit 3 (interrupt enable) is 1.
- R6: In calendar mode (control bit 0 = 1), each tick advances the seconds. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field on the same tick.
- R7: Day of week advances on every day rollover and wraps from 6 to 0.
- R8: Day of month rolls to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and after day 28 in February of a common year, carrying into the month.
- R9: A year is a leap year when it is divisible by 400, or when it is divisible by 4 but not by 100. In a leap year February rolls after day 29.
- R10: Month counts 1 to 12. A rollover from month 12 sets the month to 1 and adds one to the 16-bit year (low byte at address 10, high byte at address 11), which wraps from 65535 to 0.
- R11: A write to a counter or calendar register stores the written value even when a tick is accepted in the same cycle.
- R12: Control bit 2 (hold) stops all counting. Calendar fields do not move in counter mode, and the counters do not move in calendar mode.
- R13: The register map is: 0 control (bits 3:0 stored, upper bits read 0), 1 flag, 2 and 3 counters, 4 seconds, 5 minutes, 6 hours, 7 day of week, 8 day of month, 9 month, 10 and 11 year. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable; the 1 Hz strobe in calendar mode |
| wr_en | input | 1 | Byte write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Flag gated by the interrupt enable |
| tick_out | output | 1 | One-cycle pulse per event |

## Verification
A write or an accepted tick takes effect at the clock edge that samples it. The new value appears on `rdata` from that edge onward. `tick_out` and the flag rise at that same edge, and `tick_out` falls at the next one. The driver changes inputs only just after falling edges and queues each expectation against the address it presents there. The monitor compares a few nanoseconds after that falling edge, which is one full edge after the stimulus that produced the value. `tick_out` pulses are counted at every falling edge, so the bench checks each one-cycle pulse as a running total and never has to catch the pulse in a particular cycle.

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          tick_out
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FLAG = AW'(1);
  localparam logic [AW-1:0] A_CNTA = AW'(2);
  localparam logic [AW-1:0] A_CNTB = AW'(3);
  localparam logic [AW-1:0] A_SEC  = AW'(4);
  localparam logic [AW-1:0] A_MIN  = AW'(5);
  localparam logic [AW-1:0] A_HR   = AW'(6);
  localparam logic [AW-1:0] A_DOW  = AW'(7);
  localparam logic [AW-1:0] A_DAY  = AW'(8);
  localparam logic [AW-1:0] A_MON  = AW'(9);
  localparam logic [AW-1:0] A_YRL  = AW'(10);
  localparam logic [AW-1:0] A_YRH  = AW'(11);

  logic [3:0]  ctrl_q;
  logic        flag_q, tick_q;
  logic [7:0]  cnt_a_q, cnt_b_q;
  logic [7:0]  sec_q, min_q, hr_q, dow_q, day_q, mon_q;
  logic [15:0] year_q;

  wire cal_mode = ctrl_q[0];
  wire chain    = ctrl_q[1];
  wire hold     = ctrl_q[2];
  wire irq_en   = ctrl_q[3];

  wire w_ctrl = wr_en && addr == A_CTRL;
  wire w_flag = wr_en && addr == A_FLAG;
  wire w_cnta = wr_en && addr == A_CNTA;
  wire w_cntb = wr_en && addr == A_CNTB;
  wire w_sec  = wr_en && addr == A_SEC;
  wire w_min  = wr_en && addr == A_MIN;
  wire w_hr   = wr_en && addr == A_HR;
  wire w_dow  = wr_en && addr == A_DOW;
  wire w_day  = wr_en && addr == A_DAY;
  wire w_mon  = wr_en && addr == A_MON;
  wire w_yrl  = wr_en && addr == A_YRL;
  wire w_yrh  = wr_en && addr == A_YRH;

  wire step_cnt = tick_en && !cal_mode && !hold;
  wire step_cal = tick_en &&  cal_mode && !hold;

  wire b_inc   = step_cnt && (chain ? (cnt_a_q == 8'hFF) : 1'b1);
  wire b_event = b_inc && cnt_b_q == 8'hFF;

  wire sec_end = sec_q >= 8'd59;
  wire min_end = min_q >= 8'd59;
  wire hr_end  = hr_q  >= 8'd23;
  wire mon_end = mon_q >= 8'd12;

  wire leap = (year_q[1:0] == 2'd0) &&
              (((year_q % 16'd100) != 16'd0) || ((year_q % 16'd400) == 16'd0));

  logic [7:0] day_max;
  always_comb begin
    case (mon_q)
      8'd2:                     day_max = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  day_max = 8'd30;
      default:                  day_max = 8'd31;
    endcase
  end
  wire day_end = day_q >= day_max;

  wire c_min = step_cal && sec_end;
  wire c_hr  = c_min && min_end;
  wire c_day = c_hr && hr_end;
  wire c_mon = c_day && day_end;
  wire c_yr  = c_mon && mon_end;

  wire event_now = b_event || c_min;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (w_ctrl) ctrl_q <= wdata[3:0];
      if (event_now)   flag_q <= 1'b1;
      else if (w_flag) flag_q <= wdata[0];
      tick_q <= event_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else begin
      if (w_cnta)        cnt_a_q <= wdata;
      else if (step_cnt) cnt_a_q <= cnt_a_q + 8'd1;
      if (w_cntb)        cnt_b_q <= wdata;
      else if (b_inc)    cnt_b_q <= cnt_b_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      dow_q <= '0;
    end else begin
      if (w_sec)         sec_q <= wdata;
      else if (step_cal) sec_q <= sec_end ? 8'd0 : sec_q + 8'd1;
      if (w_min)         min_q <= wdata;
      else if (c_min)    min_q <= min_end ? 8'd0 : min_q + 8'd1;
      if (w_hr)          hr_q  <= wdata;
      else if (c_hr)     hr_q  <= hr_end ? 8'd0 : hr_q + 8'd1;
      if (w_dow)         dow_q <= wdata;
      else if (c_day)    dow_q <= (dow_q >= 8'd6) ? 8'd0 : dow_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q  <= 8'd1;
      mon_q  <= 8'd1;
      year_q <= '0;
    end else begin
      if (w_day)         day_q <= wdata;
      else if (c_day)    day_q <= day_end ? 8'd1 : day_q + 8'd1;
      if (w_mon)         mon_q <= wdata;
      else if (c_mon)    mon_q <= mon_end ? 8'd1 : mon_q + 8'd1;
      if (w_yrl || w_yrh) begin
        if (w_yrl) year_q[7:0]  <= wdata;
        if (w_yrh) year_q[15:8] <= wdata;
      end else if (c_yr) begin
        year_q <= year_q + 16'd1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {4'd0, ctrl_q};
      A_FLAG:  rdata = {7'd0, flag_q};
      A_CNTA:  rdata = cnt_a_q;
      A_CNTB:  rdata = cnt_b_q;
      A_SEC:   rdata = sec_q;
      A_MIN:   rdata = min_q;
      A_HR:    rdata = hr_q;
      A_DOW:   rdata = dow_q;
      A_DAY:   rdata = day_q;
      A_MON:   rdata = mon_q;
      A_YRL:   rdata = year_q[7:0];
      A_YRH:   rdata = year_q[15:8];
      default: rdata = 8'd0;
    endcase
  end

  assign irq      = flag_q && irq_en;
  assign tick_out = tick_q;

endmodule

// File: rtl/cal_timer_chk.sv
module cal_timer_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic          tick_out,
  input logic          flag_q,
  input logic [3:0]    ctrl_q,
  input logic [7:0]    cnt_a_q,
  input logic [7:0]    sec_q,
  input logic [7:0]    min_q,
  input logic          step_cal
);

  assert_flag_with_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> flag_q);

  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cal && sec_q == 8'd59 && !wr_en) |=> sec_q == 8'd0);

  assert_min_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cal && sec_q == 8'd59 && min_q == 8'd59 && !wr_en) |=> min_q == 8'd0);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> sec_q == $past(wdata));

  assert_hold_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && !wr_en) |=> ($stable(cnt_a_q) && $stable(sec_q)));

endmodule

bind cal_timer cal_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick_out(tick_out), .flag_q(flag_q), .ctrl_q(ctrl_q), .cnt_a_q(cnt_a_q),
  .sec_q(sec_q), .min_q(min_q), .step_cal(step_cal)
);

// File: tb/cal_timer_bench.sv
module cal_timer_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick_en = 0;
  logic       wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq, tick_out;

  cal_timer u_cal_timer (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .tick_out(tick_out));

  always #5 clk = ~clk;

  typedef struct { int a; int e; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0, tick_cnt = 0, exp_ticks = 0;
  bit done = 0;

  localparam int IRQ = 16, TCNT = 17;

  always @(negedge clk) if (tick_out) tick_cnt++;

  initial begin : monitor
    item_t it;
    int act;
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        act = (it.a == IRQ) ? int'(irq) : (it.a == TCNT) ? tick_cnt : int'(rdata);
        checks++;
        if (act != it.e) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%0d expected=%0d", it.tag, it.a, act, it.e);
        end
      end
    end
  end

  task automatic chk(input int a, input int e, input string tag);
    @(negedge clk);
    if (a < 16) addr = a[3:0];
    sbq.push_back('{a, e, tag});
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = a[3:0]; wdata = d[7:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic wr_with_tick(input int a, input int d);
    @(negedge clk);
    wr_en = 1; tick_en = 1; addr = a[3:0]; wdata = d[7:0];
    @(negedge clk);
    wr_en = 0; tick_en = 0;
  endtask

  task automatic set_date(input int yr, input int mon, input int day);
    wr(10, yr & 255); wr(11, yr >> 8); wr(9, mon); wr(8, day);
  endtask

  task automatic end_of_day();
    wr(6, 23); wr(5, 59); wr(4, 59);
    ticks(1);
    exp_ticks++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk(0, 0, "R1 ctrl"); chk(2, 0, "R1 cnt a"); chk(3, 0, "R1 cnt b");
    chk(4, 0, "R1 sec"); chk(8, 1, "R1 day"); chk(9, 1, "R1 month");
    chk(11, 0, "R1 year hi"); chk(IRQ, 0, "R1 irq"); chk(TCNT, 0, "R1 tick");

    wr(2, 250); wr(3, 3); ticks(10);
    chk(2, 4, "R2 cnt a wrap"); chk(3, 13, "R2 cnt b");
    chk(4, 0, "R12 calendar still in counter mode"); chk(TCNT, 0, "R4 no event");

    wr(0, 2); wr(2, 254); wr(3, 16); ticks(3);
    chk(2, 1, "R3 low byte"); chk(3, 17, "R3 high byte once");

    wr(0, 8'h0A); wr(2, 254); wr(3, 255); ticks(2);
    exp_ticks++;
    chk(TCNT, exp_ticks, "R4 chained wrap event"); chk(1, 1, "R5 flag set");
    chk(IRQ, 1, "R5 irq enabled"); chk(3, 0, "R3 wrap to 0");
    wr(1, 0);
    chk(1, 0, "R5 flag cleared"); chk(IRQ, 0, "R5 irq cleared");
    wr(0, 2); wr(2, 255); wr(3, 255); ticks(1);
    exp_ticks++;
    chk(1, 1, "R5 flag without enable"); chk(IRQ, 0, "R5 irq masked");
    wr(1, 0); wr(0, 0); wr(3, 255); ticks(1);
    exp_ticks++;
    chk(TCNT, exp_ticks, "R4 independent wrap event");
    wr(1, 0); wr(3, 255);
    wr_with_tick(1, 0);
    exp_ticks++;
    chk(1, 1, "R5 event beats clear");
    wr(1, 0);

    wr(0, 4); wr(2, 5); ticks(4);
    chk(2, 5, "R12 hold counter");
    wr(0, 1); ticks(4);
    chk(2, 5, "R12 counters still in calendar mode"); chk(4, 4, "R6 seconds count");
    wr(0, 5); ticks(3);
    chk(4, 4, "R12 hold calendar");
    wr(0, 1);
    chk(0, 1, "R13 ctrl readback");

    wr(4, 58); wr(5, 59); wr(6, 22); ticks(2);
    exp_ticks++;
    chk(4, 0, "R6 sec wrap"); chk(5, 0, "R6 min wrap"); chk(6, 23, "R6 hour carry");
    chk(TCNT, exp_ticks, "R4 minute event");

    wr(7, 6); set_date(2023, 4, 30); end_of_day();
    chk(8, 1, "R8 30-day month"); chk(9, 5, "R8 month carry");
    chk(7, 0, "R7 dow wrap"); chk(6, 0, "R6 hour wrap");
    set_date(2023, 5, 30); end_of_day();
    chk(8, 31, "R8 31-day month"); chk(9, 5, "R8 month held"); chk(7, 1, "R7 dow step");

    set_date(2023, 2, 28); end_of_day();
    chk(8, 1, "R8 common Feb"); chk(9, 3, "R8 Feb to Mar");
    set_date(2024, 2, 28); end_of_day();
    chk(8, 29, "R9 leap Feb 29");
    end_of_day();
    chk(8, 1, "R9 leap Feb end"); chk(9, 3, "R9 leap to Mar");
    set_date(1900, 2, 28); end_of_day();
    chk(8, 1, "R9 century not leap");
    set_date(2000, 2, 28); end_of_day();
    chk(8, 29, "R9 400-year leap");

    set_date(2023, 12, 31); end_of_day();
    chk(9, 1, "R10 month wrap"); chk(8, 1, "R10 day");
    chk(10, 2024 & 255, "R10 year lo"); chk(11, 2024 >> 8, "R10 year hi");
    set_date(255, 12, 31); end_of_day();
    chk(10, 0, "R10 byte carry lo"); chk(11, 1, "R10 byte carry hi");
    set_date(65535, 12, 31); end_of_day();
    chk(10, 0, "R10 year wrap lo"); chk(11, 0, "R10 year wrap hi");
    chk(TCNT, exp_ticks, "R4 event total");

    wr(4, 5); wr_with_tick(4, 10);
    chk(4, 10, "R11 calendar write wins");
    wr(0, 0); wr_with_tick(2, 8'h40);
    chk(2, 8'h40, "R11 counter write wins");

    wr(0, 8'hFF);
    chk(0, 15, "R13 ctrl upper bits");
    wr(0, 0);
    chk(15, 0, "R13 unused address"); chk(12, 0, "R13 unused address 12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule